// File: doc/BRIEF.md
# Vector Carry-Less Widening Multiplier

This block multiplies the lanes of two 128-bit vector operands as polynomials over GF(2). Each partial product is combined with XOR, so no carry passes from one bit position to the next. Each narrow source element pair gives one result of twice the element width. Only half of the source elements are used. The bottom form takes the even-numbered elements (index 2k), and the top form takes the odd-numbered ones (index 2k+1). Wide destination lane k holds the product of source pair k.

A two-bit size code chooses the element width:

- Code 1 multiplies bytes into 16-bit lanes.
- Code 3 multiplies 32-bit words into 64-bit lanes.
- Code 0 multiplies 64-bit doublewords into a single 128-bit result. It is allowed only while the capability input is high.

Code 2 has no meaning. Code 2, and code 0 without the capability, both raise the illegal flag and give a zeroed result. The result is registered and appears one clock after the request strobe.

Top module: `clmul_widen_vec`

## Requirements
- R1: While `rst_n` is low, `out_valid` and `out_illegal` are 0 and `out_result` is all zeros.
- R2: `out_valid` is 1 in the cycle after a cycle with `in_valid` high, and 0 after a cycle with `in_valid` low.
- R3: Each lane product is the XOR of copies of the B element shifted left by i, one copy for each set bit i of the A element. No carries are formed.
- R4: With `size_code` = 1, lane k at bits [16k+15:16k] is the product of byte 2k+s of A and byte 2k+s of B, where s = `sel_odd`. There are eight lanes.
- R5: With `size_code` = 3, lane k at bits [64k+63:64k] is the product of 32-bit word 2k+s of A and of B. There are two lanes.
- R6: With `size_code` = 0 and `wide_ok` = 1, the 128-bit result is the product of 64-bit doubleword s of A and of B.
- R7: With `size_code` = 0 and `wide_ok` = 0, the next cycle shows `out_illegal` = 1 and `out_result` = 0.
- R8: With `size_code` = 2, the next cycle shows `out_illegal` = 1 and `out_result` = 0, whatever the value of `wide_ok`.
- R9: While `in_valid` is low, `out_result` keeps its last value and operand changes have no effect on it.
- R10: After a legal operation, the most significant bit of every wide lane is 0, because the product degree is at most 2w-2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| op_a | input | 128 | First source vector |
| op_b | input | 128 | Second source vector |
| size_code | input | 2 | Element size code (0, 1, 3 legal; 2 illegal) |
| sel_odd | input | 1 | 0 selects even (bottom) elements, 1 selects odd (top) elements |
| wide_ok | input | 1 | Capability enable for the 64x64 size |
| out_valid | output | 1 | Result valid, one cycle after the request |
| out_result | output | 128 | Wide-lane products |
| out_illegal | output | 1 | Illegal encoding reported for this result |

## Verification
The hardest case to reach from the ports is the unused half of the source lanes. If the design picked the wrong parity, or leaked odd elements into a bottom product, random operands would hide it only if both halves happened to give the same result. The stimulus therefore runs directed cases in which only the unselected elements are non-zero, and the expected result is all zeros. It also runs cases with a single set bit placed in the selected element at its highest position, which exercises the top bit of each double-width lane. Random operations cover every size code and both capability settings, so the two illegal paths are mixed in among the legal ones.

// File: rtl/clmul_widen_vec.sv
module clmul_widen_vec #(
  parameter int VLEN = 128
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [VLEN-1:0] op_a,
  input  logic [VLEN-1:0] op_b,
  input  logic [1:0]      size_code,
  input  logic            sel_odd,
  input  logic            wide_ok,
  output logic            out_valid,
  output logic [VLEN-1:0] out_result,
  output logic            out_illegal
);
  localparam int N8  = VLEN / 16;
  localparam int N32 = VLEN / 64;
  localparam int N64 = VLEN / 128;
  localparam logic [1:0] SZ_DBL = 2'd0;
  localparam logic [1:0] SZ_BYTE = 2'd1;
  localparam logic [1:0] SZ_RSV = 2'd2;
  localparam logic [1:0] SZ_WORD = 2'd3;

  function automatic logic [15:0] clm8(input logic [7:0] a, input logic [7:0] b);
    logic [15:0] r;
    r = '0;
    for (int i = 0; i < 8; i++)
      if (a[i]) r = r ^ ({8'b0, b} << i);
    return r;
  endfunction

  function automatic logic [63:0] clm32(input logic [31:0] a, input logic [31:0] b);
    logic [63:0] r;
    r = '0;
    for (int i = 0; i < 32; i++)
      if (a[i]) r = r ^ ({32'b0, b} << i);
    return r;
  endfunction

  function automatic logic [127:0] clm64(input logic [63:0] a, input logic [63:0] b);
    logic [127:0] r;
    r = '0;
    for (int i = 0; i < 64; i++)
      if (a[i]) r = r ^ ({64'b0, b} << i);
    return r;
  endfunction

  logic [VLEN-1:0] res8, res32, res64, prod;
  logic            illegal;

  for (genvar k = 0; k < N8; k++) begin : g_byte
    logic [7:0] ea, eb;
    assign ea = sel_odd ? op_a[(2*k+1)*8 +: 8] : op_a[2*k*8 +: 8];
    assign eb = sel_odd ? op_b[(2*k+1)*8 +: 8] : op_b[2*k*8 +: 8];
    assign res8[k*16 +: 16] = clm8(ea, eb);
  end

  for (genvar k = 0; k < N32; k++) begin : g_word
    logic [31:0] ea, eb;
    assign ea = sel_odd ? op_a[(2*k+1)*32 +: 32] : op_a[2*k*32 +: 32];
    assign eb = sel_odd ? op_b[(2*k+1)*32 +: 32] : op_b[2*k*32 +: 32];
    assign res32[k*64 +: 64] = clm32(ea, eb);
  end

  for (genvar k = 0; k < N64; k++) begin : g_dbl
    logic [63:0] ea, eb;
    assign ea = sel_odd ? op_a[(2*k+1)*64 +: 64] : op_a[2*k*64 +: 64];
    assign eb = sel_odd ? op_b[(2*k+1)*64 +: 64] : op_b[2*k*64 +: 64];
    assign res64[k*128 +: 128] = clm64(ea, eb);
  end

  assign illegal = (size_code == SZ_RSV) || (size_code == SZ_DBL && !wide_ok);

  always_comb begin
    case (size_code)
      SZ_BYTE: prod = res8;
      SZ_WORD: prod = res32;
      SZ_DBL:  prod = res64;
      default: prod = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_illegal <= 1'b0;
      out_result  <= '0;
    end else begin
      out_valid   <= in_valid;
      out_illegal <= in_valid && illegal;
      if (in_valid) out_result <= illegal ? '0 : prod;
    end
  end
endmodule

module clmul_widen_vec_chk #(
  parameter int VLEN = 128
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic [VLEN-1:0] op_a,
  input logic [VLEN-1:0] op_b,
  input logic [1:0]      size_code,
  input logic            sel_odd,
  input logic            wide_ok,
  input logic            out_valid,
  input logic [VLEN-1:0] out_result,
  input logic            out_illegal
);
  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_valid_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_no_wide_cap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && size_code == 2'd0 && !wide_ok) |=> (out_illegal && out_result == '0));
  assert_reserved_code_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && size_code == 2'd2) |=> (out_illegal && out_result == '0));
  assert_byte_legal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && size_code == 2'd1) |=> !out_illegal);
  assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_result));
  assert_byte_msb_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && size_code == 2'd1) |=> !out_result[15]);
  assert_word_msb_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && size_code == 2'd3) |=> !out_result[63]);
  assert_dbl_msb_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && size_code == 2'd0) |=> !out_result[127]);
  assert_illegal_with_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    out_illegal |-> out_valid);
endmodule

bind clmul_widen_vec clmul_widen_vec_chk #(.VLEN(VLEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
  .size_code(size_code), .sel_odd(sel_odd), .wide_ok(wide_ok),
  .out_valid(out_valid), .out_result(out_result), .out_illegal(out_illegal)
);

// File: tb/clmul_widen_vec_test.sv
`timescale 1ns/1ps
module clmul_widen_vec_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [127:0] op_a = '0, op_b = '0;
  logic [1:0]   size_code = 2'd1;
  logic         sel_odd = 1'b0, wide_ok = 1'b0;
  logic         out_valid, out_illegal;
  logic [127:0] out_result;
  int           n_chk = 0, n_bad = 0;
  bit           done = 0;

  always #2.5 clk = ~clk;

  clmul_widen_vec uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .size_code(size_code), .sel_odd(sel_odd), .wide_ok(wide_ok),
    .out_valid(out_valid), .out_result(out_result), .out_illegal(out_illegal)
  );

  function automatic bit is_bad(input logic [1:0] sz, input bit cap);
    return sz == 2'd2 || (sz == 2'd0 && !cap);
  endfunction

  function automatic logic [127:0] model(input logic [127:0] a, input logic [127:0] b,
                                         input logic [1:0] sz, input bit s, input bit cap);
    logic [127:0] r;
    logic [63:0]  ea, eb;
    int w, lanes;
    r = '0;
    if (is_bad(sz, cap)) return r;
    w = (sz == 2'd1) ? 8 : (sz == 2'd3) ? 32 : 64;
    lanes = 128 / (2 * w);
    for (int k = 0; k < lanes; k++) begin
      ea = '0; eb = '0;
      for (int j = 0; j < w; j++) begin
        ea[j] = a[(2*k + s)*w + j];
        eb[j] = b[(2*k + s)*w + j];
      end
      for (int i = 0; i < w; i++)
        if (ea[i])
          for (int j = 0; j < w; j++)
            r[k*2*w + i + j] = r[k*2*w + i + j] ^ eb[j];
    end
    return r;
  endfunction

  function automatic string req_of(input logic [1:0] sz, input bit cap);
    if (sz == 2'd1) return "R4";
    if (sz == 2'd3) return "R5";
    if (sz == 2'd2) return "R8";
    return cap ? "R6" : "R7";
  endfunction

  task automatic run_op(input logic [127:0] a, input logic [127:0] b, input logic [1:0] sz,
                        input bit s, input bit cap, input string tag);
    logic [127:0] exp_r;
    bit exp_i;
    @(negedge clk);
    op_a = a; op_b = b; size_code = sz; sel_odd = s; wide_ok = cap; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    exp_r = model(a, b, sz, s, cap);
    exp_i = is_bad(sz, cap);
    n_chk++;
    if (out_valid !== 1'b1 || out_illegal !== exp_i || out_result !== exp_r) begin
      n_bad++;
      $display("FAIL %s/%s R2: valid=%b illegal=%b result=%h expected valid=1 illegal=%b result=%h",
               tag, req_of(sz, cap), out_valid, out_illegal, out_result, exp_i, exp_r);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [127:0] held, ra, rb;
    logic [1:0] rs;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    n_chk++;
    if (out_valid !== 1'b0 || out_illegal !== 1'b0 || out_result !== '0) begin
      n_bad++;
      $display("FAIL R1: valid=%b illegal=%b result=%h expected 0 0 0", out_valid, out_illegal, out_result);
    end
    rst_n = 1'b1;

    // R3 corner cases: all ones, single set bit, zero operand
    run_op({128{1'b1}}, {128{1'b1}}, 2'd1, 1'b0, 1'b0, "R3 ones");
    run_op({128{1'b1}}, {128{1'b1}}, 2'd3, 1'b1, 1'b0, "R3 ones");
    run_op({128{1'b1}}, {128{1'b1}}, 2'd0, 1'b1, 1'b1, "R3 ones");
    run_op(128'h0000_0000_0000_0000_0000_0000_0000_0080, {4{32'hDEADBEEF}}, 2'd1, 1'b0, 1'b0, "R3 onebit");
    run_op(128'h8000_0000_0000_0000_0000_0000_0000_0000, {4{32'h8000_0001}}, 2'd0, 1'b1, 1'b1, "R3 onebit");
    run_op('0, {4{32'hFFFF_FFFF}}, 2'd3, 1'b0, 1'b0, "R3 zero");
    // only unselected elements non-zero: result must be zero
    run_op({8{16'hFF00}}, {8{16'hFF00}}, 2'd1, 1'b0, 1'b0, "R4 odd-only bottom");
    run_op({2{64'h0000_0000_FFFF_FFFF}}, {2{64'h0000_0000_1234_5678}}, 2'd3, 1'b1, 1'b0, "R5 even-only top");
    run_op({64'h0, 64'hFFFF_FFFF_FFFF_FFFF}, {64'h0, 64'h1}, 2'd0, 1'b1, 1'b1, "R6 even-only top");
    run_op({128{1'b1}}, {128{1'b1}}, 2'd0, 1'b0, 1'b0, "R7 no cap");
    run_op({128{1'b1}}, {128{1'b1}}, 2'd2, 1'b0, 1'b1, "R8 reserved");

    run_op({128{1'b1}}, {128{1'b1}}, 2'd1, 1'b1, 1'b0, "R10 setup");
    n_chk++;
    for (int k = 0; k < 8; k++)
      if (out_result[16*k + 15] !== 1'b0) begin
        n_bad++;
        $display("FAIL R10: lane %0d msb=%b expected 0", k, out_result[16*k + 15]);
        break;
      end

    held = out_result;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      op_a = {$urandom, $urandom, $urandom, $urandom};
      size_code = 2'd3;
    end
    @(negedge clk);
    n_chk++;
    if (out_valid !== 1'b0 || out_result !== held) begin
      n_bad++;
      $display("FAIL R9: valid=%b result=%h expected valid=0 result=%h", out_valid, out_result, held);
    end

    for (int n = 0; n < 200; n++) begin
      ra = {$urandom, $urandom, $urandom, $urandom};
      rb = {$urandom, $urandom, $urandom, $urandom};
      rs = 2'($urandom);
      run_op(ra, rb, rs, 1'($urandom), 1'($urandom), "R3 random");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule